// File: doc/BRIEF.md
# Receive Framing Sequencer

This block sequences the receive side of a serial packet link. A line decoder upstream reports one event per cycle: nothing, a collision, a zero bit or a one bit. It also reports whether carrier is present. From these the sequencer steers a deserializing shift register, a CRC engine and the word handoff into a receive FIFO. The shift register reports a full word back to the sequencer on a low-true input.

A packet begins with a single one bit after a quiet line. That bit goes into the CRC engine only and never into the shift register. Every later data bit is shifted into the register and clocked into the CRC. The sequencer tracks whether the last handoff fell exactly on a word boundary. With that it can tell a clean end of packet from a truncated one. It can also drop a fragment that ends before any word has been handed off, without telling anything downstream. A collision flag is kept in a register. It collects collision reports for the whole packet and is cleared once the line returns to rest.

Top module: `rx_frame_seq`

## Requirements
- R1: After synchronous reset the sequencer rests, and with no carrier it drives shift control hold (11), CRC reset high, CRC clock low, sync_n high, end-of-packet low, incomplete low and collision low.
- R2: While resting, CRC reset is high and the collision flag is cleared on the next cycle. Events arriving without carrier have no effect.
- R3: At rest, carrier together with a one event (code 3) is taken as the preamble. CRC reset drops, the CRC clock pulses with data high, and the shift control stays at hold (11).
- R4: At rest, carrier together with a collision (code 1) or a zero (code 2) as the first event leaves CRC reset high and sets the collision flag from the next cycle.
- R5: Inside a packet with carrier present, a data event (code 2 = zero, code 3 = one) drives shift control shift (10), pulses the CRC clock and presents the bit on the CRC data output.
- R6: Inside a packet with carrier present, a collision event (code 1) sets the collision flag from the next cycle. The shift control stays at hold.
- R7: Before the first word boundary, or in the middle of a word, a data event that meets sr_full_n low drives sync_n low for that cycle and marks a word boundary.
- R8: The first data event after a word boundary shifts normally, with sync_n high, and moves the sequencer into the middle of a word.
- R9: Losing carrier before any word boundary, with the collision flag clear, loads the shift register (00) and returns to rest. Sync, end-of-packet and incomplete all stay inactive.
- R10: Losing carrier before any word boundary, with the collision flag set, loads the shift register (00), pulses sync_n low and raises end-of-packet and incomplete.
- R11: Losing carrier exactly at a word boundary loads the shift register (00), pulses sync_n low and raises end-of-packet with incomplete low.
- R12: Losing carrier in the middle of a word loads the shift register (00), pulses sync_n low and raises end-of-packet with incomplete high.
- R13: Inside a packet with carrier present and no event (code 0), the shift control holds (11), no CRC clock is produced and sync_n stays high.
- R14: The collision output is registered. Once set, it holds through the rest of the packet and for the first resting cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_i | input | 1 | Carrier present on the line |
| event_i | input | 2 | Decoded line event: 0 none, 1 collision, 2 zero, 3 one |
| sr_full_n_i | input | 1 | Shift register holds a full word, active low |
| sr_ctrl_o | output | 2 | Shift register command: 00 load, 10 shift, 11 hold |
| crc_reset_o | output | 1 | Hold the CRC engine in its initial state |
| crc_clk_o | output | 1 | Clock one bit into the CRC engine |
| crc_data_o | output | 1 | Bit value presented to the CRC engine |
| sync_n_o | output | 1 | Word handoff strobe to the FIFO, active low |
| eop_o | output | 1 | End of packet strobe |
| incomplete_o | output | 1 | Packet ended off a word boundary |
| collision_o | output | 1 | Sticky collision status for the current packet |

## Verification
The bench models the shift register as a bit counter with a four-bit word. It drives six packet shapes through the sequencer: a clean one-word packet, a two-word packet that ends on a boundary, a packet cut short in the middle of a word after a collision, a silent runt, a runt whose first event is a collision, and a runt whose first event is a zero. The clean and truncated endings separate the boundary tracking from the end-of-packet logic. The runts separate a silent discard from a reported fragment and show where the preamble goes. Quiet cycles and events that arrive without carrier show that the resting state ignores them and that the collision flag is cleared one cycle late.

// File: rtl/rx_frm_pkg.sv
package rx_frm_pkg;

    localparam int STATE_W = 3;
    localparam int EV_W    = 2;
    localparam int SROP_W  = 2;

    // Sequencer state: codes 4..7 are illegal and recover to rest.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_MAYBE = 3'd1,
        ST_FULL  = 3'd2,
        ST_MID   = 3'd3
    } frm_state_t;

    // Line decoder report.
    typedef enum logic [EV_W-1:0] {
        EV_NONE = 2'd0,
        EV_COLL = 2'd1,
        EV_ZERO = 2'd2,
        EV_ONE  = 2'd3
    } line_ev_t;

    // Shift register command.
    typedef enum logic [SROP_W-1:0] {
        SR_LOAD  = 2'b00,
        SR_SHIFT = 2'b10,
        SR_HOLD  = 2'b11
    } sr_op_t;

    // Control bundle produced by the decode stage, all active high.
    typedef struct packed {
        sr_op_t sr_op;
        logic   crc_rst;
        logic   crc_clk;
        logic   crc_bit;
        logic   word_sync;
        logic   eop;
        logic   incomplete;
    } frm_ctl_t;

    function automatic logic ev_is_data(input line_ev_t e);
        return (e == EV_ZERO) || (e == EV_ONE);
    endfunction

    function automatic logic ev_bit(input line_ev_t e);
        return e == EV_ONE;
    endfunction

endpackage

// File: rtl/rx_frm_regs.sv
module rx_frm_regs
    import rx_frm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frm_state_t state_d,
    input  logic       col_d,
    output frm_state_t state_q,
    output logic       col_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            col_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
        end
    end

endmodule

// File: rtl/rx_frm_decode.sv
module rx_frm_decode
    import rx_frm_pkg::*;
(
    input  frm_state_t state_q,
    input  logic       col_q,
    input  logic       carrier,
    input  line_ev_t   ev,
    input  logic       sr_full,
    output frm_state_t state_d,
    output logic       col_d,
    output frm_ctl_t   ctl
);

    logic data_ev;
    logic coll_ev;

    assign data_ev = ev_is_data(ev);
    assign coll_ev = (ev == EV_COLL);

    always_comb begin
        state_d   = state_q;
        col_d     = col_q;
        ctl       = '0;
        ctl.sr_op = SR_HOLD;

        case (state_q)
            ST_IDLE: begin
                ctl.crc_rst = 1'b1;
                col_d       = 1'b0;
                if (carrier) begin
                    state_d = ST_MAYBE;
                    if (ev == EV_ONE) begin
                        // preamble: CRC only, register untouched
                        ctl.crc_rst = 1'b0;
                        ctl.crc_clk = 1'b1;
                        ctl.crc_bit = 1'b1;
                    end else if (ev != EV_NONE) begin
                        col_d = 1'b1;
                    end
                end
            end

            ST_MAYBE, ST_MID: begin
                if (!carrier) begin
                    state_d   = ST_IDLE;
                    ctl.sr_op = SR_LOAD;
                    if (state_q == ST_MID || col_q) begin
                        ctl.eop        = 1'b1;
                        ctl.incomplete = 1'b1;
                        ctl.word_sync  = 1'b1;
                    end
                end else if (coll_ev) begin
                    col_d = 1'b1;
                end else if (data_ev) begin
                    ctl.sr_op   = SR_SHIFT;
                    ctl.crc_clk = 1'b1;
                    ctl.crc_bit = ev_bit(ev);
                    if (sr_full) begin
                        state_d       = ST_FULL;
                        ctl.word_sync = 1'b1;
                    end
                end
            end

            ST_FULL: begin
                if (!carrier) begin
                    state_d       = ST_IDLE;
                    ctl.sr_op     = SR_LOAD;
                    ctl.eop       = 1'b1;
                    ctl.word_sync = 1'b1;
                end else if (coll_ev) begin
                    col_d = 1'b1;
                end else if (data_ev) begin
                    ctl.sr_op   = SR_SHIFT;
                    ctl.crc_clk = 1'b1;
                    ctl.crc_bit = ev_bit(ev);
                    state_d     = ST_MID;
                end
            end

            default: begin
                state_d   = ST_IDLE;
                ctl.sr_op = SR_LOAD;
            end
        endcase
    end

endmodule

// File: rtl/rx_frm_pins.sv
module rx_frm_pins
    import rx_frm_pkg::*;
(
    input  frm_ctl_t          ctl,
    input  logic              col_q,
    output logic [SROP_W-1:0] sr_ctrl_o,
    output logic              crc_reset_o,
    output logic              crc_clk_o,
    output logic              crc_data_o,
    output logic              sync_n_o,
    output logic              eop_o,
    output logic              incomplete_o,
    output logic              collision_o
);

    assign sr_ctrl_o    = ctl.sr_op;
    assign crc_reset_o  = ctl.crc_rst;
    assign crc_clk_o    = ctl.crc_clk;
    assign crc_data_o   = ctl.crc_bit;
    assign sync_n_o     = ~ctl.word_sync;
    assign eop_o        = ctl.eop;
    assign incomplete_o = ctl.incomplete;
    assign collision_o  = col_q;

endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
    import rx_frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_i,
    input  logic [EV_W-1:0]   event_i,
    input  logic              sr_full_n_i,
    output logic [SROP_W-1:0] sr_ctrl_o,
    output logic              crc_reset_o,
    output logic              crc_clk_o,
    output logic              crc_data_o,
    output logic              sync_n_o,
    output logic              eop_o,
    output logic              incomplete_o,
    output logic              collision_o
);

    frm_state_t state_q;
    frm_state_t state_d;
    logic       col_q;
    logic       col_d;
    frm_ctl_t   ctl;
    line_ev_t   ev;
    logic       sr_full;

    assign ev      = line_ev_t'(event_i);
    assign sr_full = ~sr_full_n_i;

    rx_frm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .col_d   (col_d),
        .state_q (state_q),
        .col_q   (col_q)
    );

    rx_frm_decode u_decode (
        .state_q (state_q),
        .col_q   (col_q),
        .carrier (carrier_i),
        .ev      (ev),
        .sr_full (sr_full),
        .state_d (state_d),
        .col_d   (col_d),
        .ctl     (ctl)
    );

    rx_frm_pins u_pins (
        .ctl          (ctl),
        .col_q        (col_q),
        .sr_ctrl_o    (sr_ctrl_o),
        .crc_reset_o  (crc_reset_o),
        .crc_clk_o    (crc_clk_o),
        .crc_data_o   (crc_data_o),
        .sync_n_o     (sync_n_o),
        .eop_o        (eop_o),
        .incomplete_o (incomplete_o),
        .collision_o  (collision_o)
    );

endmodule

// File: rtl/rx_frame_seq_chk.sv
module rx_frame_seq_chk
    import rx_frm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       carrier_i,
    input logic [1:0] event_i,
    input logic       sr_full_n_i,
    input frm_state_t state_q,
    input logic [1:0] sr_ctrl_o,
    input logic       crc_reset_o,
    input logic       crc_clk_o,
    input logic       crc_data_o,
    input logic       sync_n_o,
    input logic       eop_o,
    input logic       incomplete_o,
    input logic       collision_o
);

    // R2
    idle_clears_col_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !carrier_i) |=> !collision_o);

    // R3
    preamble_crc_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && carrier_i && event_i == 2'd3)
        |-> (crc_clk_o && crc_data_o && !crc_reset_o && sr_ctrl_o == 2'b11));

    // R4
    bad_first_event_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && carrier_i && (event_i == 2'd1 || event_i == 2'd2))
        |=> collision_o);

    // R5
    active_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && carrier_i && event_i[1])
        |-> (sr_ctrl_o == 2'b10 && crc_clk_o && crc_data_o == event_i[0]));

    // R6
    coll_event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && carrier_i && event_i == 2'd1) |=> collision_o);

    // R7
    word_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_MAYBE || state_q == ST_MID) && carrier_i && event_i[1] && !sr_full_n_i)
        |-> !sync_n_o);

    // R7
    word_ready_state_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_MAYBE || state_q == ST_MID) && carrier_i && event_i[1] && !sr_full_n_i)
        |=> state_q == ST_FULL);

    // R8
    full_to_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL && carrier_i && event_i[1]) |=> state_q == ST_MID);

    // R9
    silent_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MAYBE && !carrier_i && !collision_o)
        |-> (sync_n_o && !eop_o && !incomplete_o && sr_ctrl_o == 2'b00));

    // R11
    eop_loads_chk: assert property (@(posedge clk) disable iff (rst)
        eop_o |-> (sr_ctrl_o == 2'b00 && !sync_n_o));

    // R13
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && carrier_i && event_i == 2'd0)
        |-> (sr_ctrl_o == 2'b11 && !crc_clk_o && sync_n_o));

    // R14
    col_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && collision_o) |=> collision_o);

endmodule

bind rx_frame_seq rx_frame_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .carrier_i    (carrier_i),
    .event_i      (event_i),
    .sr_full_n_i  (sr_full_n_i),
    .state_q      (state_q),
    .sr_ctrl_o    (sr_ctrl_o),
    .crc_reset_o  (crc_reset_o),
    .crc_clk_o    (crc_clk_o),
    .crc_data_o   (crc_data_o),
    .sync_n_o     (sync_n_o),
    .eop_o        (eop_o),
    .incomplete_o (incomplete_o),
    .collision_o  (collision_o)
);

// File: tb/test_rx_frame_seq.sv
`timescale 1ns/1ps
module test_rx_frame_seq;

    localparam int WORD = 4;
    localparam logic [1:0] H = 2'b11;
    localparam logic [1:0] S = 2'b10;
    localparam logic [1:0] L = 2'b00;

    typedef struct {
        logic [8:0] v;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       carrier_i = 1'b0;
    logic [1:0] event_i = 2'd0;
    logic       sr_full_n_i = 1'b1;
    logic [1:0] sr_ctrl_o;
    logic       crc_reset_o, crc_clk_o, crc_data_o, sync_n_o;
    logic       eop_o, incomplete_o, collision_o;

    int   total = 0;
    int   bad = 0;
    int   bits = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    rx_frame_seq i_rx_frame_seq (
        .clk          (clk),
        .rst          (rst),
        .carrier_i    (carrier_i),
        .event_i      (event_i),
        .sr_full_n_i  (sr_full_n_i),
        .sr_ctrl_o    (sr_ctrl_o),
        .crc_reset_o  (crc_reset_o),
        .crc_clk_o    (crc_clk_o),
        .crc_data_o   (crc_data_o),
        .sync_n_o     (sync_n_o),
        .eop_o        (eop_o),
        .incomplete_o (incomplete_o),
        .collision_o  (collision_o)
    );

    // f = {crc_reset, crc_clk, crc_data, sync_n, eop, incomplete, collision}
    task automatic step(input logic car, input logic [1:0] ev,
                        input logic [1:0] sr, input logic [6:0] f, input string tag);
        exp_t e;
        @(negedge clk);
        carrier_i   = car;
        event_i     = ev;
        sr_full_n_i = (bits != WORD - 1);
        e.v   = {sr, f};
        e.tag = tag;
        q.push_back(e);
        #1;
        // shift register model: counts bits since last load
        if (sr_ctrl_o == L)      bits = 0;
        else if (sr_ctrl_o == S) bits = (bits + 1) % WORD;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [8:0] act;
                e   = q.pop_front();
                act = {sr_ctrl_o, crc_reset_o, crc_clk_o, crc_data_o, sync_n_o,
                       eop_o, incomplete_o, collision_o};
                total++;
                if (act !== e.v) begin
                    bad++;
                    $display("FAIL %s: actual=%b expected=%b", e.tag, act, e.v);
                end
            end
        end
    end

    // driver
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // clean one-word packet
        step(0, 0, H, 7'b1001000, "R1");
        step(1, 3, H, 7'b0111000, "R3");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 3, S, 7'b0111000, "R5");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 3, S, 7'b0110000, "R7");
        step(1, 0, H, 7'b0001000, "R13");
        step(0, 0, L, 7'b0000100, "R11");
        step(0, 0, H, 7'b1001000, "R2");

        // truncated in mid-word after a collision
        step(1, 3, H, 7'b0111000, "R3");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 2, S, 7'b0100000, "R7");
        step(1, 2, S, 7'b0101000, "R8");
        step(1, 1, H, 7'b0001000, "R6");
        step(1, 0, H, 7'b0001001, "R14");
        step(0, 0, L, 7'b0000111, "R12");
        step(0, 0, H, 7'b1001001, "R14");
        step(0, 0, H, 7'b1001000, "R2");

        // silent runt, then events without carrier
        step(1, 3, H, 7'b0111000, "R3");
        step(1, 2, S, 7'b0101000, "R5");
        step(0, 0, L, 7'b0001000, "R9");
        step(0, 3, H, 7'b1001000, "R2");
        step(0, 1, H, 7'b1001000, "R2");

        // runt opening with a collision
        step(1, 1, H, 7'b1001000, "R4");
        step(1, 2, S, 7'b0101001, "R4");
        step(0, 0, L, 7'b0000111, "R10");
        step(0, 0, H, 7'b1001001, "R14");
        step(0, 0, H, 7'b1001000, "R2");

        // runt opening with a zero
        step(1, 2, H, 7'b1001000, "R4");
        step(1, 0, H, 7'b0001001, "R4");
        step(0, 0, L, 7'b0000111, "R10");
        step(0, 0, H, 7'b1001001, "R14");
        step(0, 0, H, 7'b1001000, "R2");

        // two words, clean end
        step(1, 3, H, 7'b0111000, "R3");
        step(1, 3, S, 7'b0111000, "R5");
        step(1, 3, S, 7'b0111000, "R5");
        step(1, 3, S, 7'b0111000, "R5");
        step(1, 3, S, 7'b0110000, "R7");
        step(1, 2, S, 7'b0101000, "R8");
        step(1, 3, S, 7'b0111000, "R5");
        step(1, 2, S, 7'b0101000, "R5");
        step(1, 3, S, 7'b0110000, "R7");
        step(0, 0, L, 7'b0000100, "R11");
        step(0, 0, H, 7'b1001000, "R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule